// File: doc/BRIEF.md
# UART Receive/Transmit Buffer and Status Flags

This block sits between a processor register port and the two serial shift engines of a UART. On the receive side, each time the receive shifter reports a finished frame, the block takes the byte and its parity verdict and stores the byte in a small first-in first-out receive buffer, two entries deep by default. Software pulls bytes out one at a time with a data-register read strobe. The block reports an overrun when a frame completes with no room left. In that case the stored bytes are kept and the new byte is lost.

On the transmit side there is a single holding register. It hands its byte to the transmit shifter as soon as the shifter is idle, or in the same cycle the shifter reports that it has finished. The block tracks whether the shifter is busy. A six-bit status word gathers the buffer and busy indications with two sticky error flags, which software clears by writing ones.

Baud timing, serial shifting, framing and parity computation live elsewhere. Here they appear only as strobes and a parity-bad input.

Top module: `uart_buf_stat`

## Requirements
- R1: After reset `status_o` reads 6'b000001, `tx_load_o` is 0 and `rd_data_o` is 0.
- R2: A pulse on `rd_data_i` pops the oldest stored byte, which appears on `rd_data_o` one cycle later. Bytes leave in arrival order. A read strobe while the buffer is empty leaves `rd_data_o` and `status_o` unchanged.
- R3: Status bit 1 (receive ready) is 1 the cycle after a byte is stored. It returns to 0 only once every stored byte has been read.
- R4: Status bit 3 (second byte) is 1 while two bytes are held. It clears the cycle after the older byte is read.
- R5: Status bit 4 (overrun) is set the cycle after `rx_done_i` arrives while two bytes are held and `rd_data_i` is low. The held bytes are unchanged and the new byte is dropped. If `rd_data_i` is high in that same cycle, the new byte is stored and no overrun is flagged.
- R6: Status bit 5 (parity error) is set the cycle after a byte is stored with `parity_en_i`=1 and `rx_parity_bad_i`=1. It is never set while `parity_en_i`=0, and never set by a dropped byte.
- R7: A pulse on `status_wr_i` clears bit 5 and/or bit 4 where `status_wdata_i` has a 1 in that position. A 0 bit leaves the flag as it is, and the other bit positions are ignored. If a new error event falls in the same cycle as the clear, the flag stays 1.
- R8: Status bit 0 (transmit buffer empty) goes to 0 the cycle after `tx_wr_i`. It returns to 1 the cycle after the byte is handed to the shifter, unless a new write arrived in the handoff cycle.
- R9: `tx_load_o` is high, with `tx_data_o` showing the held byte, in any cycle in which the holding register is full and either the shifter is idle or `tx_done_i` is high. A write in that same cycle stays pending for the next handoff.
- R10: Status bit 2 (transmit busy) is 1 the cycle after a handoff. It returns to 0 the cycle after `tx_done_i` when no new handoff takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parity_en_i | input | 1 | Parity checking enable |
| rx_done_i | input | 1 | Receive shifter finished a frame |
| rx_data_i | input | 8 | Byte from receive shifter |
| rx_parity_bad_i | input | 1 | Parity mismatch for the finished frame |
| rd_data_i | input | 1 | Receive data register read strobe |
| rd_data_o | output | 8 | Last byte popped from the receive buffer |
| tx_wr_i | input | 1 | Transmit data register write strobe |
| tx_wdata_i | input | 8 | Byte written for transmission |
| tx_done_i | input | 1 | Transmit shifter finished its byte |
| tx_load_o | output | 1 | Handoff of held byte to transmit shifter |
| tx_data_o | output | 8 | Byte handed to transmit shifter |
| status_wr_i | input | 1 | Status register write strobe |
| status_wdata_i | input | 6 | Status write data, ones clear bits 5 and 4 |
| status_o | output | 6 | {parity err, overrun, second byte, tx busy, rx ready, tx empty} |

## Verification
The bound checker watches the cycle-level rules on every clock. These cover the overrun set and the preserved second-byte flag when a frame arrives on a full buffer, the rule that a written zero never clears an error, the empty and busy updates around a write or a handoff, and the rule that a handoff happens only when the shifter is idle or finishing. The bench scenarios are the only place to see byte ordering through the receive buffer and the values actually returned by reads. They also cover the value held after an empty read, the parity matrix across enable and mismatch, and the pending byte kept when a write collides with a handoff.

// File: rtl/uart_bs_pkg.sv
package uart_bs_pkg;
  localparam int unsigned ST_W    = 6;
  localparam int unsigned ST_TEMP = 0;
  localparam int unsigned ST_RRDY = 1;
  localparam int unsigned ST_TBSY = 2;
  localparam int unsigned ST_R2ND = 3;
  localparam int unsigned ST_OVR  = 4;
  localparam int unsigned ST_PAR  = 5;
  localparam int unsigned N_ERR   = 2;
  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_PAR = 1;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(i))      mem_q[i] <= data_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_err_flag.sv
module uart_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              busy_o
);
  logic              full_q, busy_q;
  logic [DATA_W-1:0] hold_q;

  assign load_o = full_q && (!busy_q || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (wr_i)        full_q <= 1'b1;
      else if (load_o) full_q <= 1'b0;
      if (wr_i) hold_q <= wdata_i;
      if (load_o)      busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign data_o  = hold_q;
  assign empty_o = !full_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/uart_buf_stat.sv
module uart_buf_stat
  import uart_bs_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RX_DEPTH = 2,
  localparam int unsigned CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              parity_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_parity_bad_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_done_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              status_wr_i,
  input  logic [ST_W-1:0]   status_wdata_i,
  output logic [ST_W-1:0]   status_o
);
  logic [CNT_W-1:0]  rx_cnt;
  logic [DATA_W-1:0] rx_head;
  logic              rx_pop, rx_room, rx_push;
  logic [N_ERR-1:0]  err_set, err_clr, err_q;
  logic              tx_empty, tx_busy;

  assign rx_pop  = rd_data_i && (rx_cnt != '0);
  assign rx_room = (rx_cnt != CNT_W'(RX_DEPTH)) || rx_pop;
  assign rx_push = rx_done_i && rx_room;

  uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .count_o (rx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_data_o <= '0;
    else if (rx_pop) rd_data_o <= rx_head;
  end

  assign err_set[ERR_OVR] = rx_done_i && !rx_room;
  assign err_set[ERR_PAR] = rx_push && parity_en_i && rx_parity_bad_i;
  assign err_clr[ERR_OVR] = status_wr_i && status_wdata_i[ST_OVR];
  assign err_clr[ERR_PAR] = status_wr_i && status_wdata_i[ST_PAR];

  for (genvar e = 0; e < N_ERR; e++) begin : g_err
    uart_err_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set[e]),
      .clr_i  (err_clr[e]),
      .flag_o (err_q[e])
    );
  end

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .done_i  (tx_done_i),
    .load_o  (tx_load_o),
    .data_o  (tx_data_o),
    .empty_o (tx_empty),
    .busy_o  (tx_busy)
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_PAR]  = err_q[ERR_PAR];
    status_o[ST_OVR]  = err_q[ERR_OVR];
    status_o[ST_R2ND] = rx_cnt > CNT_W'(1);
    status_o[ST_TBSY] = tx_busy;
    status_o[ST_RRDY] = rx_cnt != '0;
    status_o[ST_TEMP] = tx_empty;
  end
endmodule

// File: rtl/uart_buf_stat_chk.sv
module uart_buf_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_done_i,
  input logic       rd_data_i,
  input logic       tx_wr_i,
  input logic       tx_done_i,
  input logic       tx_load_o,
  input logic       status_wr_i,
  input logic [5:0] status_wdata_i,
  input logic [5:0] status_o
);
  AST_R2ND_IMPLIES_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] |-> status_o[1]); // R4
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && rx_done_i && !rd_data_i |=> status_o[4]); // R5
  AST_FULL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && rx_done_i && !rd_data_i |=> status_o[3]); // R5
  AST_ZERO_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_wr_i && !status_wdata_i[5] && status_o[5] |=> status_o[5]); // R7
  AST_OVR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_wr_i && status_wdata_i[4] && !(status_o[3] && rx_done_i && !rd_data_i)
    |=> !status_o[4]); // R7
  AST_WR_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !status_o[0]); // R8
  AST_LOAD_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> status_o[2]); // R10
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> (!status_o[2] || tx_done_i) && !status_o[0]); // R9
endmodule

bind uart_buf_stat uart_buf_stat_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_done_i      (rx_done_i),
  .rd_data_i      (rd_data_i),
  .tx_wr_i        (tx_wr_i),
  .tx_done_i      (tx_done_i),
  .tx_load_o      (tx_load_o),
  .status_wr_i    (status_wr_i),
  .status_wdata_i (status_wdata_i),
  .status_o       (status_o)
);

// File: tb/tb_uart_buf_stat.sv
`timescale 1ns/1ps
module tb_uart_buf_stat;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       parity_en_i = 1'b0, rx_done_i = 1'b0, rx_parity_bad_i = 1'b0, rd_data_i = 1'b0;
  logic [7:0] rx_data_i = '0, tx_wdata_i = '0;
  logic       tx_wr_i = 1'b0, tx_done_i = 1'b0, status_wr_i = 1'b0;
  logic [5:0] status_wdata_i = '0;
  logic [7:0] rd_data_o, tx_data_o;
  logic       tx_load_o;
  logic [5:0] status_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  uart_buf_stat dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] d, input logic bad);
    rx_data_i = d; rx_parity_bad_i = bad; rx_done_i = 1'b1;
    tick();
    rx_done_i = 1'b0; rx_parity_bad_i = 1'b0;
  endtask

  task automatic pop();
    rd_data_i = 1'b1; tick(); rd_data_i = 1'b0;
  endtask

  task automatic swr(input logic [5:0] v);
    status_wdata_i = v; status_wr_i = 1'b1; tick(); status_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c, prev;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 status", status_o, 6'b000001);
    chk("R1 tx_load", tx_load_o, 0);
    chk("R1 rd_data", rd_data_o, 0);

    // R6 parity matrix, R3 ready, R7 clear
    for (int en = 0; en < 2; en++) begin
      for (int bad = 0; bad < 2; bad++) begin
        parity_en_i = en[0];
        a = 8'(en * 64 + bad * 16 + 3);
        push(a, bad[0]);
        chk("R6 parity", status_o[5], en & bad);
        chk("R3 ready", status_o[1], 1);
        pop();
        chk("R2 data", rd_data_o, a);
        chk("R3 ready clr", status_o[1], 0);
        swr(6'b001111);
        chk("R7 zero ignored", status_o[5], en & bad);
        swr(6'b100000);
        chk("R7 par clr", status_o[5], 0);
      end
    end
    parity_en_i = 1'b1;

    // R2/R4/R5 FIFO order and overrun sweep
    for (int i = 0; i < 8; i++) begin
      a = 8'(i * 37 + 5); b = 8'(i * 11 + 200); c = 8'(i * 73 + 1);
      push(a, 1'b0);
      chk("R4 one byte", status_o[3], 0);
      push(b, 1'b0);
      chk("R4 second", status_o[3], 1);
      push(c, 1'b1);
      chk("R5 overrun status", status_o, 6'b011011);
      pop();
      chk("R2 oldest", rd_data_o, a);
      chk("R4 clr", status_o[3], 0);
      chk("R3 still ready", status_o[1], 1);
      pop();
      chk("R5 kept byte", rd_data_o, b);
      chk("R3 empty", status_o[1], 0);
      pop();
      chk("R2 empty read data", rd_data_o, b);
      chk("R2 empty read status", status_o, 6'b010001);
      swr(6'b101111);
      chk("R7 zero keeps ovr", status_o[4], 1);
      swr(6'b010000);
      chk("R7 ovr clr", status_o[4], 0);
    end

    // R5 read frees room in same cycle
    push(8'h11, 1'b0); push(8'h22, 1'b0);
    rx_data_i = 8'h33; rx_done_i = 1'b1; rd_data_i = 1'b1;
    tick();
    rx_done_i = 1'b0; rd_data_i = 1'b0;
    chk("R5 no ovr on read", status_o[4], 0);
    chk("R2 pop same cycle", rd_data_o, 8'h11);
    pop(); chk("R2 order b", rd_data_o, 8'h22);
    pop(); chk("R5 accepted c", rd_data_o, 8'h33);

    // R7 clear and event same cycle
    push(8'h44, 1'b0); push(8'h55, 1'b0);
    rx_data_i = 8'h66; rx_done_i = 1'b1;
    status_wdata_i = 6'b010000; status_wr_i = 1'b1;
    tick();
    rx_done_i = 1'b0; status_wr_i = 1'b0;
    chk("R7 event wins", status_o[4], 1);
    pop(); pop(); swr(6'b110000);
    chk("R7 all clear", status_o, 6'b000001);

    // R8/R9/R10 transmit sweep
    for (int i = 0; i < 6; i++) begin
      a = 8'(i * 41 + 7); b = 8'(i * 29 + 128); c = ~a;
      tx_wdata_i = a; tx_wr_i = 1'b1; tick(); tx_wr_i = 1'b0;
      chk("R8 not empty", status_o[0], 0);
      chk("R9 load idle", tx_load_o, 1);
      chk("R9 load data", tx_data_o, a);
      tick();
      chk("R8 empty after load", status_o[0], 1);
      chk("R10 busy", status_o[2], 1);
      chk("R9 no load empty", tx_load_o, 0);
      tx_wdata_i = b; tx_wr_i = 1'b1; tick(); tx_wr_i = 1'b0;
      chk("R9 wait busy", tx_load_o, 0);
      tx_done_i = 1'b1; tx_wdata_i = c; tx_wr_i = 1'b1;
      #1;
      chk("R9 load on done", tx_load_o, 1);
      chk("R9 done data", tx_data_o, b);
      tick();
      tx_done_i = 1'b0; tx_wr_i = 1'b0;
      chk("R8 pending kept", status_o[0], 0);
      chk("R10 busy again", status_o[2], 1);
      tx_done_i = 1'b1;
      #1;
      chk("R9 pending data", tx_data_o, c);
      tick();
      chk("R8 empty", status_o[0], 1);
      tick();
      tx_done_i = 1'b0;
      chk("R10 idle", status_o[2], 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule